// File: doc/BRIEF.md
# Signed/Unsigned Wide Multiplier

This block multiplies two 32-bit operands and returns the full 64-bit product as a high word and a low word. A mode input selects two's-complement or unsigned operands. The datapath never multiplies anything wider than one half-word by another. In signed mode each operand is first turned into its magnitude. Four half-word partial products are then merged, with their carries, into a 64-bit magnitude. That magnitude is negated afterwards when exactly one operand was negative.

Alongside the product the block returns a 5-bit flag word. Bit 4 is extend, bit 3 negative, bit 2 zero, bit 1 overflow and bit 0 carry. The extend bit is copied from the flag word supplied with the operands. The other four bits are recomputed. A multiply with a zero operand bypasses the datapath and returns zero with the zero flag set.

A request is a one-cycle `start` pulse that is accepted while `busy` is low. Operands, mode and input flags are sampled on that edge. Three edges later `done` pulses for one cycle. The product and flags stay on their outputs until the next `done`.

Top module: `wide_mult`

## Requirements
- R1: With `signed_mode` low, {`prod_hi`,`prod_lo`} equals the unsigned 64-bit product of `op_a` and `op_b`.
- R2: With `signed_mode` high, {`prod_hi`,`prod_lo`} equals the two's-complement 64-bit product of the operands read as signed 32-bit values.
- R3: If either operand is zero, the product is zero and `flags_out` equals {extend from `flags_in`[4], 0, 1, 0, 0} (bit 4 down to bit 0).
- R4: For non-zero operands, `flags_out`[3] equals product bit 63 in both modes and `flags_out`[2] is 0.
- R5: `flags_out`[4] equals `flags_in`[4] of the accepted request. `flags_out`[1:0] are always 0. `flags_in`[3:0] have no effect.
- R6: `done` is high for exactly one cycle, three clock edges after the edge that accepts `start`. Product and flags hold their values between `done` pulses.
- R7: A `start` raised while `busy` is high is ignored. `busy` is high during the two cycles after acceptance, so requests can be accepted every third cycle.
- R8: After reset `done` and `busy` are 0, and the product and `flags_out` are all zero.
- R9: The extreme operands 0x80000000 and 0xFFFFFFFF give exact results in both modes. For example, 0x80000000 squared in signed mode gives 0x4000000000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, accepted when `busy` is low |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| op_a | input | 32 | Multiplier operand |
| op_b | input | 32 | Multiplicand operand |
| flags_in | input | 5 | Flag word at request time; only bit 4 is used |
| busy | output | 1 | Pipeline holds a request that cannot yet be followed |
| done | output | 1 | One-cycle pulse: product and flags are valid |
| prod_hi | output | 32 | Product bits 63..32 |
| prod_lo | output | 32 | Product bits 31..0 |
| flags_out | output | 5 | {extend, negative, zero, overflow, carry} |

## Verification
The hardest paths to reach are the negation carry that ripples from the low word into the high word and the case where both cross-product low halves carry into the high word in the same cycle. Uniformly random operands rarely produce either pattern. The stimulus therefore draws most operands from a pool of boundary values (0, 1, 0x80000000, 0xFFFFFFFF, 0xFFFF, 0x10000, 0x7FFFFFFF) mixed with random words. Those values force long carry chains, magnitudes that equal their own negation, and products that are negative but whose low word is zero. A held `start` line also steps the pipeline through back-to-back acceptance and ignored requests.

// File: rtl/mulw_pkg.sv
package mulw_pkg;
  localparam int FLAG_W = 5;
  localparam int FLG_X  = 4;
  localparam int FLG_N  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_V  = 1;
  localparam int FLG_C  = 0;
  localparam int NUM_PP = 4;

  typedef logic [FLAG_W-1:0] flags_t;

  function automatic flags_t make_flags(input logic x_bit, input logic n_bit, input logic z_bit);
    flags_t f;
    f        = '0;
    f[FLG_X] = x_bit;
    f[FLG_N] = n_bit;
    f[FLG_Z] = z_bit;
    return f;
  endfunction
endpackage

// File: rtl/mulw_sign_strip.sv
module mulw_sign_strip #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic         signed_mode,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = signed_mode & val[W-1];
    if (neg) mag = ~val + {{(W-1){1'b0}}, 1'b1};
    else     mag = val;
  end
endmodule

// File: rtl/mulw_partial_array.sv
module mulw_partial_array #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0]                      mr,
  input  logic [2*HW-1:0]                      md,
  output logic [mulw_pkg::NUM_PP-1:0][2*HW-1:0] pp
);
  // index bit 0 picks the multiplier half, bit 1 the multiplicand half
  for (genvar k = 0; k < mulw_pkg::NUM_PP; k++) begin : g_pp
    localparam int MR_SEL = k % 2;
    localparam int MD_SEL = k / 2;
    logic [HW-1:0] x_half;
    logic [HW-1:0] y_half;
    assign x_half = mr[MR_SEL*HW +: HW];
    assign y_half = md[MD_SEL*HW +: HW];
    assign pp[k]  = {{HW{1'b0}}, x_half} * {{HW{1'b0}}, y_half};
  end
endmodule

// File: rtl/mulw_merge.sv
module mulw_merge #(
  parameter int HW = 16
) (
  input  logic [mulw_pkg::NUM_PP-1:0][2*HW-1:0] pp,
  input  logic                                  negate,
  output logic [4*HW-1:0]                       result
);
  localparam int WW = 2 * HW;

  logic [HW+1:0] mid;
  logic [WW-1:0] lo_mag;
  logic [WW-1:0] hi_mag;
  logic [WW:0]   lo_inc;
  logic [WW-1:0] hi_neg;

  always_comb begin
    mid    = {2'b00, pp[0][WW-1:HW]} + {2'b00, pp[1][HW-1:0]} + {2'b00, pp[2][HW-1:0]};
    lo_mag = {mid[HW-1:0], pp[0][HW-1:0]};
    hi_mag = pp[3]
           + {{(WW-2){1'b0}}, mid[HW+1:HW]}
           + {{HW{1'b0}}, pp[1][WW-1:HW]}
           + {{HW{1'b0}}, pp[2][WW-1:HW]};
    lo_inc = {1'b0, ~lo_mag} + {{WW{1'b0}}, 1'b1};
    hi_neg = ~hi_mag + {{(WW-1){1'b0}}, lo_inc[WW]};
    if (negate) result = {hi_neg, lo_inc[WW-1:0]};
    else        result = {hi_mag, lo_mag};
  end
endmodule

// File: rtl/wide_mult.sv
module wide_mult #(
  parameter int HALF_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        signed_mode,
  input  logic [2*HALF_W-1:0]         op_a,
  input  logic [2*HALF_W-1:0]         op_b,
  input  logic [mulw_pkg::FLAG_W-1:0] flags_in,
  output logic                        busy,
  output logic                        done,
  output logic [2*HALF_W-1:0]         prod_hi,
  output logic [2*HALF_W-1:0]         prod_lo,
  output logic [mulw_pkg::FLAG_W-1:0] flags_out
);
  import mulw_pkg::*;

  localparam int WORD_W = 2 * HALF_W;
  localparam int PROD_W = 2 * WORD_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic unused_flag_bits;
  assign unused_flag_bits = ^flags_in[FLG_X-1:0];

  // stage 1: magnitudes and sign
  logic [WORD_W-1:0] mag_a, mag_b;
  logic              neg_a, neg_b;
  logic              accept;

  mulw_sign_strip #(.W(WORD_W)) i_strip_a (.val(op_a), .signed_mode(signed_mode), .mag(mag_a), .neg(neg_a));
  mulw_sign_strip #(.W(WORD_W)) i_strip_b (.val(op_b), .signed_mode(signed_mode), .mag(mag_b), .neg(neg_b));

  logic              s1_v_q, s1_v_d;
  logic [WORD_W-1:0] s1_mr_q, s1_md_q;
  logic              s1_neg_q, s1_zero_q, s1_x_q;

  // stage 2: partial products
  logic [NUM_PP-1:0][WORD_W-1:0] pp_comb;
  logic                          s2_v_q, s2_v_d;
  logic [NUM_PP-1:0][WORD_W-1:0] s2_pp_q;
  logic                          s2_neg_q, s2_zero_q, s2_x_q;

  mulw_partial_array #(.HW(HALF_W)) i_pp (.mr(s1_mr_q), .md(s1_md_q), .pp(pp_comb));

  // stage 3: merge, sign, flags
  logic [PROD_W-1:0] merged;
  logic [PROD_W-1:0] prod_d, prod_q;
  flags_t            flags_d, flags_q;
  logic              done_d, done_q;

  mulw_merge #(.HW(HALF_W)) i_merge (.pp(s2_pp_q), .negate(s2_neg_q), .result(merged));

  always_comb begin
    accept = start & ~busy;
    s1_v_d = accept;
    s2_v_d = s1_v_q;
    done_d = s2_v_q;
    if (s2_zero_q) begin
      prod_d  = '0;
      flags_d = make_flags(s2_x_q, 1'b0, 1'b1);
    end else begin
      prod_d  = merged;
      flags_d = make_flags(s2_x_q, merged[PROD_W-1], 1'b0);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d;
      s2_v_q <= s2_v_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_mr_q   <= '0;
      s1_md_q   <= '0;
      s1_neg_q  <= 1'b0;
      s1_zero_q <= 1'b0;
      s1_x_q    <= 1'b0;
    end else if (accept) begin
      s1_mr_q   <= mag_a;
      s1_md_q   <= mag_b;
      s1_neg_q  <= neg_a ^ neg_b;
      s1_zero_q <= (op_a == '0) | (op_b == '0);
      s1_x_q    <= flags_in[FLG_X];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s2_pp_q   <= '0;
      s2_neg_q  <= 1'b0;
      s2_zero_q <= 1'b0;
      s2_x_q    <= 1'b0;
    end else if (s1_v_q) begin
      s2_pp_q   <= pp_comb;
      s2_neg_q  <= s1_neg_q;
      s2_zero_q <= s1_zero_q;
      s2_x_q    <= s1_x_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prod_q  <= '0;
      flags_q <= '0;
    end else if (s2_v_q) begin
      prod_q  <= prod_d;
      flags_q <= flags_d;
    end
  end

  assign busy      = s1_v_q | s2_v_q;
  assign done      = done_q;
  assign prod_hi   = prod_q[PROD_W-1:WORD_W];
  assign prod_lo   = prod_q[WORD_W-1:0];
  assign flags_out = flags_q;
endmodule

// File: rtl/wide_mult_chk.sv
module wide_mult_chk #(
  parameter int HALF_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        signed_mode,
  input logic [2*HALF_W-1:0]         op_a,
  input logic [2*HALF_W-1:0]         op_b,
  input logic [mulw_pkg::FLAG_W-1:0] flags_in,
  input logic                        busy,
  input logic                        done,
  input logic [2*HALF_W-1:0]         prod_hi,
  input logic [2*HALF_W-1:0]         prod_lo,
  input logic [mulw_pkg::FLAG_W-1:0] flags_out
);
  localparam int WW = 2 * HALF_W;
  localparam int PW = 2 * WW;

  logic          acc;
  logic [PW-1:0] prod;
  logic [PW-1:0] ext_a_u, ext_b_u, ext_a_s, ext_b_s;
  assign acc     = start & ~busy;
  assign prod    = {prod_hi, prod_lo};
  assign ext_a_u = {{WW{1'b0}}, op_a};
  assign ext_b_u = {{WW{1'b0}}, op_b};
  assign ext_a_s = {{WW{op_a[WW-1]}}, op_a};
  assign ext_b_s = {{WW{op_b[WW-1]}}, op_b};

  AST_UNSIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && !signed_mode, 3) |-> prod == $past(ext_a_u, 3) * $past(ext_b_u, 3)); // R1
  AST_SIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && signed_mode, 3) |-> prod == $past(ext_a_s, 3) * $past(ext_b_s, 3)); // R2
  AST_ZERO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && (op_a == '0 || op_b == '0), 3) |-> (prod == '0 && flags_out[3:0] == 4'b0100)); // R3
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[3] == prod_hi[WW-1]); // R4
  AST_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[1:0] == 2'b00); // R5
  AST_X_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc, 3) |-> flags_out[4] == $past(flags_in[4], 3)); // R5
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(acc, 3)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(prod) && $stable(flags_out))); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start && busy, 3) |-> !done); // R7
endmodule

bind wide_mult wide_mult_chk #(.HALF_W(HALF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
  .op_a(op_a), .op_b(op_b), .flags_in(flags_in), .busy(busy), .done(done),
  .prod_hi(prod_hi), .prod_lo(prod_lo), .flags_out(flags_out)
);

// File: tb/test_wide_mult.sv
module test_wide_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [4:0]  flags_in = '0;
  logic        busy, done;
  logic [31:0] prod_hi, prod_lo;
  logic [4:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  wide_mult i_wide_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .op_a(op_a), .op_b(op_b), .flags_in(flags_in), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo), .flags_out(flags_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic sm);
    logic signed [63:0] sp;
    if (sm) begin
      sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
      return sp;
    end
    return {32'h0, a} * {32'h0, b};
  endfunction

  // behavioural reference: remaining-cycle counter and pending result
  int          m_cnt = 0;
  logic [63:0] m_prod = '0, m_last = '0;
  logic [4:0]  m_flags = '0, m_last_flags = '0;
  string       m_tag = "R1";
  string       m_ftag = "R4 R5";
  bit          model_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
    end else if (start && m_cnt < 2) begin
      m_cnt   = 3;
      m_prod  = ref_prod(op_a, op_b, signed_mode);
      if (op_a == 0 || op_b == 0) begin
        m_flags = {flags_in[4], 4'b0100};
        m_tag   = "R3";
        m_ftag  = "R3";
      end else begin
        m_flags = {flags_in[4], m_prod[63], 3'b000};
        m_ftag  = "R4 R5";
        if (op_a == 32'h8000_0000 || op_a == 32'hFFFF_FFFF ||
            op_b == 32'h8000_0000 || op_b == 32'hFFFF_FFFF) m_tag = "R9";
        else if (signed_mode) m_tag = "R2";
        else m_tag = "R1";
      end
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk(busy == (m_cnt >= 2), "R7 busy", {63'h0, busy}, {63'h0, (m_cnt >= 2)});
      chk(done == (m_cnt == 1), "R6 R7 done", {63'h0, done}, {63'h0, (m_cnt == 1)});
      if (m_cnt == 1) begin
        m_last       = m_prod;
        m_last_flags = m_flags;
        chk({prod_hi, prod_lo} == m_prod, m_tag, {prod_hi, prod_lo}, m_prod);
        chk(flags_out == m_flags, m_ftag, {59'h0, flags_out}, {59'h0, m_flags});
      end else begin
        chk({prod_hi, prod_lo} == m_last, "R6 hold", {prod_hi, prod_lo}, m_last);
        chk(flags_out == m_last_flags, "R6 hold flags", {59'h0, flags_out}, {59'h0, m_last_flags});
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sm, input logic [4:0] f);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b; signed_mode = sm; flags_in = f;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] pick(input int sel);
    case (sel % 10)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_FFFF;
      5: return 32'h0001_0000;
      6: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(done == 1'b0 && busy == 1'b0, "R8", {62'h0, done, busy}, 64'h0);
    chk({prod_hi, prod_lo} == 64'h0, "R8", {prod_hi, prod_lo}, 64'h0);
    chk(flags_out == 5'h0, "R8", {59'h0, flags_out}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    issue(32'd7, 32'd9, 1'b0, 5'h00);                    // R1
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 5'h1F);    // R1, R5 extend kept, other input flags ignored
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'h00);    // R9 R4 negative in unsigned mode
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'h10);    // R9 signed -1 * -1
    issue(32'h8000_0000, 32'h8000_0000, 1'b1, 5'h00);    // R9
    issue(32'h8000_0000, 32'h0000_0001, 1'b1, 5'h0F);    // R9 negative result
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 5'h10);    // R9 unsigned
    issue(32'hFFFF_FFF9, 32'd3, 1'b1, 5'h00);            // R2 mixed signs
    issue(32'h0, 32'hDEAD_BEEF, 1'b1, 5'h1B);            // R3
    issue(32'h1234_0000, 32'h0, 1'b0, 5'h04);            // R3

    // R7: start held high across busy cycles
    @(negedge clk);
    start = 1'b1; signed_mode = 1'b1;
    for (int i = 0; i < 9; i++) begin
      op_a = $urandom; op_b = pick(i); flags_in = 5'(i);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      issue(pick($urandom), pick($urandom), 1'($urandom), 5'($urandom));
    end

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule